// File: doc/BRIEF.md
# Instruction Window with Miss-Overlap Tracking

This block models the occupancy of a reorder buffer inside a trace-driven core timing model. Decoded trace records enter through a valid/ready port and each takes the slot at the tail of a circular window. A record that is a memory operation sends a request to an outbound queue in the same step. The request carries the index of its slot, and the memory models answer later, in any order, by returning that index. Records that are not memory operations count as complete as soon as they are stored.

Records leave the window in order at the head, one per cycle, once complete. If the record at the head is an unfinished memory operation that nothing has yet covered, it is an exposed long-latency miss, and the block raises a stall flag for the dispatch stage. It also walks the rest of the window one slot per cycle and tracks which registers depend on the miss. Every later unfinished memory operation whose sources do not depend on it is flagged as overlapped. When such a miss reaches the head, it waits for its reply without charging a stall of its own.

Top module: `instr_window`

## Requirements
- R1: After reset the window is empty: `trc_ready` is 1, and `req_valid`, `hd_valid`, `hd_stall`, `scan_busy` and `rsp_err` are all 0.
- R2: The window holds DEPTH records (128 by default). While it holds DEPTH records, `trc_ready` is 0 and no record is taken.
- R3: An accepted memory record (`trc_mem`=1) queues a request whose `req_tag` is its slot index. Slots are given out as 0, 1, 2, … and wrap modulo DEPTH. A record with `trc_mem`=0 sends no request and is complete at once.
- R4: A reply (`rsp_valid` with `rsp_tag`) marks that slot complete, and replies may come in any order. `hd_valid` is 1, and the head record leaves in that cycle, only when the head slot is complete and no scan is running. Records therefore leave strictly in slot order.
- R5: The request queue holds DEPTH entries, keeps tags in request order, and holds its front entry while `req_ready` is 0.
- R6: While the head is an unfinished memory operation that is not overlapped, `hd_stall` is 1. One scan of the slots behind the head starts, advancing one slot per cycle with `scan_busy` at 1, and no record leaves while it runs.
- R7: A scan flags a later unfinished memory operation as overlapped (`hd_ovl`=1 when it reaches the head) only if none of its two source registers carries a value that depends on the head. The dependence starts at the head's destination and spreads through any record that reads a dependent register. A record that writes a register from independent sources makes that register independent again.
- R8: An overlapped unfinished memory operation at the head keeps `hd_stall` at 0 and starts no scan.
- R9: A reply whose tag names an empty slot changes no slot, and it sets `rsp_err`, which stays 1 until reset.
- R10: Trace records keep being accepted while a scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_valid | input | 1 | Trace record offered |
| trc_ready | output | 1 | Window can take a record |
| trc_mem | input | 1 | Record is a memory operation |
| trc_dst | input | RW | Destination register |
| trc_src0 | input | RW | First source register |
| trc_src1 | input | RW | Second source register |
| req_valid | output | 1 | Request queue not empty |
| req_ready | input | 1 | Consumer takes the front request |
| req_tag | output | AW | Slot index of the front request |
| rsp_valid | input | 1 | Reply present |
| rsp_tag | input | AW | Slot index the reply completes |
| hd_valid | output | 1 | Head record leaves this cycle |
| hd_tag | output | AW | Head slot index |
| hd_dst | output | RW | Head destination register |
| hd_ovl | output | 1 | Head was flagged as overlapped |
| hd_stall | output | 1 | Exposed miss is holding the head |
| scan_busy | output | 1 | Overlap scan running |
| rsp_err | output | 1 | Sticky flag for a reply to an empty slot |

## Verification
The hardest case to reach is a scan that meets a mixed dependence chain. An unfinished head miss has to sit in front of records that read its result, then a record that overwrites a tainted register from clean sources, and then misses on both sides of that overwrite. Records must keep arriving during the walk, and replies must hold back the right slots so that an overlapped miss reaches the head still unfinished. The stimulus empties the window first, so the miss lands at the head. It then streams the chain back to back while the scan trails the tail by one slot. The replies are ordered so that the dependent miss and the last independent miss finish early, while the first independent miss is left pending until the records ahead of it have left.

// File: rtl/iw_pkg.sv
package iw_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic int unsigned iw_pow2_ok(input int unsigned v);
      return ((v >= 2) && ((v & (v - 1)) == 0)) ? 1 : 0;
   endfunction
endpackage

// File: rtl/iw_req_fifo.sv
module iw_req_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   output logic         full_o,
   input  logic         ready_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] n;
   logic          pop;

   assign valid_o = (n != '0);
   assign full_o  = (n == CW'(DEPTH));
   assign pop     = valid_o & ready_i;
   assign data_o  = store[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         n  <= '0;
      end else begin
         if (push_i) wp <= wp + AW'(1);
         if (pop)    rp <= rp + AW'(1);
         n <= n + CW'(push_i) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) store[wp] <= data_i;
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   p_order_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/iw_scan.sv
module iw_scan #(
   parameter int DEPTH         = 128,
   parameter int NREG          = 32,
   parameter bit RENAME_CLEARS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [$clog2(DEPTH)-1:0] head_i,
   input  logic [$clog2(NREG)-1:0]  head_dst_i,
   input  logic [$clog2(DEPTH)-1:0] tail_i,
   output logic [$clog2(DEPTH)-1:0] rd_idx_o,
   input  logic                     rd_mem_i,
   input  logic                     rd_done_i,
   input  logic [$clog2(NREG)-1:0]  rd_dst_i,
   input  logic [$clog2(NREG)-1:0]  rd_src0_i,
   input  logic [$clog2(NREG)-1:0]  rd_src1_i,
   output logic                     mark_o,
   output logic [$clog2(DEPTH)-1:0] mark_idx_o,
   output logic                     busy_o
);
   import iw_pkg::*;
   localparam int AW = $clog2(DEPTH);

   scan_state_e   state;
   logic [AW-1:0] ptr;
   logic [NREG-1:0] taint, taint_nxt, dst_bit;
   logic          at_end, dep, clr_on_clean;

   generate
      if (RENAME_CLEARS) begin : g_rename
         assign clr_on_clean = 1'b1;
      end else begin : g_keep
         assign clr_on_clean = 1'b0;
      end
   endgenerate

   assign busy_o     = (state == SCAN_RUN);
   assign at_end     = (ptr == tail_i);
   assign rd_idx_o   = ptr;
   assign mark_idx_o = ptr;
   assign dst_bit    = NREG'(1) << rd_dst_i;
   assign dep        = taint[rd_src0_i] | taint[rd_src1_i];
   assign mark_o     = busy_o && !at_end && !dep && rd_mem_i && !rd_done_i;

   always_comb begin
      if (dep)               taint_nxt = taint | dst_bit;
      else if (clr_on_clean) taint_nxt = taint & ~dst_bit;
      else                   taint_nxt = taint;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SCAN_IDLE;
         ptr   <= '0;
         taint <= '0;
      end else if (start_i) begin
         state <= SCAN_RUN;
         ptr   <= head_i + AW'(1);
         taint <= NREG'(1) << head_dst_i;
      end else if (busy_o) begin
         if (at_end) begin
            state <= SCAN_IDLE;
         end else begin
            ptr   <= ptr + AW'(1);
            taint <= taint_nxt;
         end
      end
   end

   p_scan_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !at_end && !start_i) |=> (ptr == $past(ptr) + AW'(1)));
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i);
endmodule

// File: rtl/instr_window.sv
module instr_window #(
   parameter int DEPTH         = 128,
   parameter int NREG          = 32,
   parameter bit RENAME_CLEARS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trc_valid,
   output logic                     trc_ready,
   input  logic                     trc_mem,
   input  logic [$clog2(NREG)-1:0]  trc_dst,
   input  logic [$clog2(NREG)-1:0]  trc_src0,
   input  logic [$clog2(NREG)-1:0]  trc_src1,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [$clog2(DEPTH)-1:0] req_tag,
   input  logic                     rsp_valid,
   input  logic [$clog2(DEPTH)-1:0] rsp_tag,
   output logic                     hd_valid,
   output logic [$clog2(DEPTH)-1:0] hd_tag,
   output logic [$clog2(NREG)-1:0]  hd_dst,
   output logic                     hd_ovl,
   output logic                     hd_stall,
   output logic                     scan_busy,
   output logic                     rsp_err
);
   import iw_pkg::*;
   localparam int AW = $clog2(DEPTH);
   localparam int RW = $clog2(NREG);
   localparam int CW = AW + 1;

   generate
      if (iw_pow2_ok(DEPTH) == 0) begin : g_bad_depth
         $error("instr_window: DEPTH must be a power of two, at least 2");
      end
      if (iw_pow2_ok(NREG) == 0) begin : g_bad_nreg
         $error("instr_window: NREG must be a power of two, at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] vld, mem_q, done_q, ovl_q;
   logic [RW-1:0]    dst_q  [DEPTH];
   logic [RW-1:0]    src0_q [DEPTH];
   logic [RW-1:0]    src1_q [DEPTH];
   logic [AW-1:0]    head, tail;
   logic [CW-1:0]    cnt;
   logic             head_scanned, err_q;

   logic          accept, retire, start, fifo_full;
   logic          busy, mark;
   logic [AW-1:0] mark_idx, rd_idx;
   logic          head_miss;

   assign accept    = trc_valid & trc_ready;
   assign trc_ready = (cnt != CW'(DEPTH)) & ~fifo_full;
   assign head_miss = vld[head] & mem_q[head] & ~done_q[head] & ~ovl_q[head];
   assign start     = head_miss & ~head_scanned & ~busy;
   assign retire    = vld[head] & done_q[head] & ~busy;

   assign hd_valid  = retire;
   assign hd_tag    = head;
   assign hd_dst    = dst_q[head];
   assign hd_ovl    = ovl_q[head];
   assign hd_stall  = head_miss;
   assign scan_busy = busy;
   assign rsp_err   = err_q;

   // slot status bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= '0;
         mem_q  <= '0;
         done_q <= '0;
         ovl_q  <= '0;
      end else begin
         if (accept) begin
            vld[tail]    <= 1'b1;
            mem_q[tail]  <= trc_mem;
            done_q[tail] <= ~trc_mem;
            ovl_q[tail]  <= 1'b0;
         end
         if (rsp_valid && vld[rsp_tag]) done_q[rsp_tag] <= 1'b1;
         if (mark)   ovl_q[mark_idx] <= 1'b1;
         if (retire) vld[head] <= 1'b0;
      end
   end

   // register fields of each slot
   always_ff @(posedge clk) begin
      if (accept) begin
         dst_q[tail]  <= trc_dst;
         src0_q[tail] <= trc_src0;
         src1_q[tail] <= trc_src1;
      end
   end

   // pointers, occupancy, scan bookkeeping, reply error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head         <= '0;
         tail         <= '0;
         cnt          <= '0;
         head_scanned <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         if (accept) tail <= tail + AW'(1);
         if (retire) head <= head + AW'(1);
         cnt <= cnt + CW'(accept) - CW'(retire);
         if (retire)     head_scanned <= 1'b0;
         else if (start) head_scanned <= 1'b1;
         if (rsp_valid && !vld[rsp_tag]) err_q <= 1'b1;
      end
   end

   iw_req_fifo #(.DEPTH(DEPTH), .W(AW)) u_req_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (accept & trc_mem),
      .data_i  (tail),
      .full_o  (fifo_full),
      .ready_i (req_ready),
      .valid_o (req_valid),
      .data_o  (req_tag)
   );

   iw_scan #(.DEPTH(DEPTH), .NREG(NREG), .RENAME_CLEARS(RENAME_CLEARS)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .head_i     (head),
      .head_dst_i (dst_q[head]),
      .tail_i     (tail),
      .rd_idx_o   (rd_idx),
      .rd_mem_i   (mem_q[rd_idx]),
      .rd_done_i  (done_q[rd_idx]),
      .rd_dst_i   (dst_q[rd_idx]),
      .rd_src0_i  (src0_q[rd_idx]),
      .rd_src1_i  (src1_q[rd_idx]),
      .mark_o     (mark),
      .mark_idx_o (mark_idx),
      .busy_o     (busy)
   );

   p_count_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == CW'($countones(vld)));
   p_req_on_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && trc_mem) |=> req_valid);
   p_retire_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> !hd_valid);
   p_ovl_head_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[head] && ovl_q[head]) |-> (!hd_stall && !start));
   p_bad_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !vld[rsp_tag]) |=> rsp_err);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |=> rsp_err);
endmodule

// File: tb/instr_window_tb.sv
module instr_window_tb;
   localparam int DEPTH = 128;
   localparam int NREG  = 32;
   localparam int AW    = $clog2(DEPTH);
   localparam int RW    = $clog2(NREG);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trc_valid = 1'b0, trc_ready, trc_mem = 1'b0;
   logic [RW-1:0] trc_dst = '0, trc_src0 = '0, trc_src1 = '0;
   logic          req_valid, req_ready = 1'b1;
   logic [AW-1:0] req_tag;
   logic          rsp_valid = 1'b0;
   logic [AW-1:0] rsp_tag = '0;
   logic          hd_valid, hd_ovl, hd_stall, scan_busy, rsp_err;
   logic [AW-1:0] hd_tag;
   logic [RW-1:0] hd_dst;

   always #4 clk = ~clk;

   instr_window #(.DEPTH(DEPTH), .NREG(NREG)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .trc_valid(trc_valid), .trc_ready(trc_ready), .trc_mem(trc_mem),
      .trc_dst(trc_dst), .trc_src0(trc_src0), .trc_src1(trc_src1),
      .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
      .hd_valid(hd_valid), .hd_tag(hd_tag), .hd_dst(hd_dst), .hd_ovl(hd_ovl),
      .hd_stall(hd_stall), .scan_busy(scan_busy), .rsp_err(rsp_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   int nslot = 0;
   bit finished = 1'b0;
   logic [AW-1:0] req_q [$];
   logic [AW:0]   ret_q [$];   // {expected overlap flag, tag}

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic push_rec(input bit m, input int d, input int s0, input int s1,
                           input bit eovl);
      trc_valid = 1'b1;
      trc_mem   = m;
      trc_dst   = RW'(d);
      trc_src0  = RW'(s0);
      trc_src1  = RW'(s1);
      @(posedge clk); #1;
      trc_valid = 1'b0;
      if (m) req_q.push_back(AW'(nslot));
      ret_q.push_back({eovl, AW'(nslot)});
      nslot++;
   endtask

   task automatic reply(input int t);
      rsp_valid = 1'b1;
      rsp_tag   = AW'(t);
      @(posedge clk); #1;
      rsp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic at_neg();
      @(negedge clk);
   endtask

   task automatic back_to_drive();
      @(posedge clk); #1;
   endtask

   // scoreboard monitor: requests and retirements
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (req_valid && req_ready) begin
            if (req_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected request tag", int'(req_tag), -1);
            end else begin
               logic [AW-1:0] e;
               e = req_q.pop_front();
               chk(req_tag == e, "R3", "request tag", int'(req_tag), int'(e));
            end
         end
         if (hd_valid) begin
            if (ret_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected retire tag", int'(hd_tag), -1);
            end else begin
               logic [AW:0] e;
               e = ret_q.pop_front();
               chk(hd_tag == e[AW-1:0], "R4", "retire order tag", int'(hd_tag),
                   int'(e[AW-1:0]));
               chk(hd_ovl == e[AW], "R7", "overlap flag at retire", int'(hd_ovl),
                   int'(e[AW]));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      at_neg();
      chk(trc_ready == 1'b1, "R1", "trc_ready", int'(trc_ready), 1);
      chk(req_valid == 1'b0 && hd_valid == 1'b0, "R1", "req/hd valid",
          int'({req_valid, hd_valid}), 0);
      chk(hd_stall == 1'b0 && scan_busy == 1'b0 && rsp_err == 1'b0, "R1",
          "stall/busy/err", int'({hd_stall, scan_busy, rsp_err}), 0);
      back_to_drive();

      // R3: non-memory record, no request, completes at once
      push_rec(1'b0, 1, 2, 3, 1'b0);
      idle(3);
      chk(req_q.size() == 0 && ret_q.size() == 0, "R3", "non-mem record retired",
          ret_q.size(), 0);

      // R5 hold, R3 tags, R4 out-of-order replies, R6 stall, R7 dependents
      req_ready = 1'b0;
      push_rec(1'b1, 5, 1, 1, 1'b0);   // slot 1
      push_rec(1'b1, 6, 5, 5, 1'b0);   // slot 2 depends on 1
      push_rec(1'b1, 7, 6, 0, 1'b0);   // slot 3 depends on 2
      at_neg();
      chk(req_valid == 1'b1 && req_tag == AW'(1), "R5", "front held tag",
          int'(req_tag), 1);
      chk(hd_stall == 1'b1, "R6", "stall on exposed head miss", int'(hd_stall), 1);
      back_to_drive();
      idle(2);
      at_neg();
      chk(req_valid == 1'b1 && req_tag == AW'(1), "R5", "front still held",
          int'(req_tag), 1);
      back_to_drive();
      req_ready = 1'b1;
      idle(6);
      reply(3);
      reply(2);
      idle(3);
      at_neg();
      chk(hd_valid == 1'b0 && ret_q.size() == 3, "R4", "no retire past pending head",
          ret_q.size(), 3);
      back_to_drive();
      reply(1);
      idle(6);
      chk(ret_q.size() == 0, "R4", "slots 1..3 retired", ret_q.size(), 0);

      // R6/R7/R10: scan over a mixed dependence chain with continuous insertion
      push_rec(1'b1, 8, 0, 0, 1'b0);    // slot 4 head miss, dst 8
      push_rec(1'b0, 9, 8, 0, 1'b0);    // slot 5 taints 9
      push_rec(1'b1, 10, 9, 0, 1'b0);   // slot 6 dependent miss
      push_rec(1'b0, 9, 0, 0, 1'b0);    // slot 7 clean overwrite of 9
      push_rec(1'b1, 11, 9, 2, 1'b1);   // slot 8 independent -> overlapped
      push_rec(1'b1, 12, 3, 3, 1'b1);   // slot 9 independent -> overlapped
      chk(scan_busy == 1'b1, "R10", "records accepted while scan busy",
          int'(scan_busy), 1);
      idle(6);
      at_neg();
      chk(scan_busy == 1'b0 && hd_stall == 1'b1, "R6", "scan done, stall held",
          int'({scan_busy, hd_stall}), 1);
      back_to_drive();
      reply(9);
      reply(6);
      idle(3);
      at_neg();
      chk(hd_valid == 1'b0 && hd_tag == AW'(4), "R4", "head waits at slot 4",
          int'(hd_tag), 4);
      back_to_drive();
      reply(4);
      idle(8);
      at_neg();
      chk(hd_tag == AW'(8), "R8", "head reached slot 8", int'(hd_tag), 8);
      chk(hd_ovl == 1'b1 && hd_stall == 1'b0, "R8", "overlapped head no stall",
          int'({hd_ovl, hd_stall}), 2);
      chk(scan_busy == 1'b0 && hd_valid == 1'b0, "R8", "no scan for overlapped head",
          int'({scan_busy, hd_valid}), 0);
      back_to_drive();
      reply(8);
      idle(4);
      chk(ret_q.size() == 0, "R7", "slots 4..9 retired", ret_q.size(), 0);

      // R9: reply to empty slot
      reply(50);
      at_neg();
      chk(rsp_err == 1'b1, "R9", "error flag set", int'(rsp_err), 1);
      chk(hd_valid == 1'b0 && trc_ready == 1'b1, "R9", "no state change",
          int'({hd_valid, trc_ready}), 1);
      back_to_drive();
      idle(5);
      at_neg();
      chk(rsp_err == 1'b1, "R9", "error flag sticky", int'(rsp_err), 1);
      back_to_drive();

      // R2: fill the window, with wrap of slot tags (R3)
      for (int i = 0; i < DEPTH; i++) push_rec(1'b1, 13, 13, 0, 1'b0);
      at_neg();
      chk(trc_ready == 1'b0, "R2", "ready low when full", int'(trc_ready), 0);
      back_to_drive();
      trc_valid = 1'b1;
      trc_mem   = 1'b1;
      idle(3);
      at_neg();
      chk(trc_ready == 1'b0, "R2", "still full while offered", int'(trc_ready), 0);
      back_to_drive();
      trc_valid = 1'b0;
      idle(3);
      for (int i = 0; i < DEPTH; i++) reply((10 + i) % DEPTH);
      idle(10);
      chk(ret_q.size() == 0, "R2", "all full-window slots retired", ret_q.size(), 0);
      chk(req_q.size() == 0, "R3", "all requests seen", req_q.size(), 0);
      at_neg();
      chk(trc_ready == 1'b1 && hd_valid == 1'b0, "R2", "window empty again",
          int'({trc_ready, hd_valid}), 2);

      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule